// File: doc/BRIEF.md
# Receive Lane Delay Sweep Trainer

This block trains the sampling point of a single serial receive lane. During training the transmitter sends a known word, normally an alternating bit pattern. The block steps a programmable input delay element through every tap, starting at tap zero. At each tap it compares received words against the expected word and marks the tap as passing or failing. After the last tap it picks the centre of the widest passing window and loads that tap into the delay element.

The procedure runs open loop and takes a fixed number of steps. A fixed number of words is thrown away after each tap change so that the delay line and the deserializer can settle. After that, a programmable number of valid words is compared. Taps that pass in isolation near the edges of the eye cannot move the result, because only the longest contiguous run of passing taps counts. Word alignment runs after this block has finished and is not part of it.

Top module: `eye_sweep_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `tap_o`, `load_o`, `done_o`, `fail_o`, `first_o` and `last_o` are all zero.
- R2: A `start_i` pulse accepted while idle sets `tap_o` to 0 with a one-cycle `load_o`. After that, `tap_o` rises by exactly one per step through every tap up to TAPS-1, and every tap change comes with a `load_o` pulse in the same cycle.
- R3: After each tap change, the first SETTLE_WORDS valid words are discarded and their content has no effect on the result.
- R4: A tap passes only when all of the next `cmp_count_i` valid words equal `pattern_i` (a value of 0 counts as 1). A mismatch in any one of them, including the last, fails the tap. Words with `rx_valid_i` low are ignored.
- R5: The window is the longest run of consecutive passing taps. When two runs have the same length, the one at the lower tap wins. `first_o` and `last_o` report its ends.
- R6: When at least one tap passes, the final `tap_o` is floor((first+last)/2). It is loaded with one `load_o` pulse in the same cycle that `done_o` rises, with `fail_o` low.
- R7: When no tap passes, `fail_o` and `done_o` go high together, and `tap_o`, `first_o` and `last_o` are 0.
- R8: A `start_i` pulse that arrives while a sweep is running has no effect on the tap sequence or on the result.
- R9: `done_o`, `fail_o` and the final tap stay unchanged until the next accepted `start_i`, which clears `done_o` and `fail_o`.
- R10: One training run produces exactly TAPS+1 `load_o` pulses: one for each tap and one for the final tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that begins a training run |
| rx_valid_i | input | 1 | Received word is valid |
| rx_word_i | input | W | Received parallel word |
| pattern_i | input | W | Expected training word |
| cmp_count_i | input | CNT_W | Valid words compared at each tap |
| tap_o | output | TW | Delay tap setting |
| load_o | output | 1 | One-cycle strobe that loads `tap_o` into the delay element |
| done_o | output | 1 | Training finished |
| fail_o | output | 1 | No passing tap was found |
| first_o | output | TW | Lowest tap of the chosen window |
| last_o | output | TW | Highest tap of the chosen window |

## Verification
The bench keeps the full 32-tap sweep and builds the block with 8-bit words, a settle count of 2 and a 6-bit compare counter. Every run therefore visits all taps in a few hundred cycles. A lane model in the bench decides from the current tap whether each word is clean or corrupted. This lets the bench set up any pass map, including scattered edge passes, equal-length windows, an empty eye, a fully open eye and a single-tap eye at the top end. The lane model also places errors only in settle words, only in invalid words, or only in the last compared word, so that each counting boundary is exercised.

// File: rtl/eye_pkg.sv
package eye_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SWEEP  = 2'd1,
    ST_FINISH = 2'd2
  } sweep_state_t;
endpackage

// File: rtl/eye_word_check.sv
module eye_word_check #(
  parameter int W            = 10,
  parameter int SETTLE_WORDS = 3,
  parameter int CNT_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic             rx_valid,
  input  logic [W-1:0]     rx_word,
  input  logic [W-1:0]     pattern,
  input  logic [CNT_W-1:0] cmp_count,
  output logic             tap_end,
  output logic             tap_pass
);
  localparam int SW = $clog2(SETTLE_WORDS + 2);

  logic [SW-1:0]    settle_q;
  logic [CNT_W-1:0] cmp_q;
  logic             bad_q;
  logic             settled;
  logic             word_ok;
  logic             last_word;

  assign settled   = (settle_q == SW'(SETTLE_WORDS));
  assign word_ok   = (rx_word == pattern);
  assign last_word = ({1'b0, cmp_q} + 1'b1) >= {1'b0, cmp_count};
  assign tap_end   = en && rx_valid && settled && last_word;
  assign tap_pass  = !bad_q && word_ok;

  always_ff @(posedge clk) begin
    if (rst || clear || tap_end) begin
      settle_q <= '0;
      cmp_q    <= '0;
      bad_q    <= 1'b0;
    end else if (en && rx_valid) begin
      if (!settled) begin
        settle_q <= settle_q + 1'b1;
      end else begin
        cmp_q <= cmp_q + 1'b1;
        if (!word_ok) bad_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eye_window_track.sv
module eye_window_track #(
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          rec,
  input  logic          pass,
  input  logic [TW-1:0] tap,
  output logic          any_pass,
  output logic [TW-1:0] best_first,
  output logic [TW-1:0] best_last
);
  localparam int LW = TW + 1;

  logic [TW-1:0] run_start_q, best_start_q;
  logic [LW-1:0] run_len_q, best_len_q;
  logic [LW-1:0] ext_len;
  logic [TW-1:0] ext_start;

  assign ext_len   = run_len_q + 1'b1;
  assign ext_start = (run_len_q == '0) ? tap : run_start_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_start_q  <= '0;
      run_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (rec) begin
      if (pass) begin
        run_start_q <= ext_start;
        run_len_q   <= ext_len;
        if (ext_len > best_len_q) begin
          best_len_q   <= ext_len;
          best_start_q <= ext_start;
        end
      end else begin
        run_len_q <= '0;
      end
    end
  end

  assign any_pass   = (best_len_q != '0);
  assign best_first = best_start_q;
  assign best_last  = best_start_q + TW'(best_len_q - 1'b1);
endmodule

// File: rtl/eye_sweep_ctrl.sv
module eye_sweep_ctrl #(
  parameter int W            = 10,
  parameter int TAPS         = 32,
  parameter int SETTLE_WORDS = 3,
  parameter int CNT_W        = 8,
  localparam int TW          = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rx_valid_i,
  input  logic [W-1:0]     rx_word_i,
  input  logic [W-1:0]     pattern_i,
  input  logic [CNT_W-1:0] cmp_count_i,
  output logic [TW-1:0]    tap_o,
  output logic             load_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [TW-1:0]    first_o,
  output logic [TW-1:0]    last_o
);
  import eye_pkg::*;

  sweep_state_t  state_q;
  logic [TW-1:0] tap_q, first_q, last_q;
  logic          load_q, done_q, fail_q;
  logic          start_acc, sweeping;
  logic          tap_end, tap_pass;
  logic          any_pass;
  logic [TW-1:0] win_first, win_last;
  logic [TW:0]   win_sum;
  logic [TW-1:0] win_mid;

  assign start_acc = start_i && (state_q == ST_IDLE);
  assign sweeping  = (state_q == ST_SWEEP);
  assign win_sum   = {1'b0, win_first} + {1'b0, win_last};
  assign win_mid   = win_sum[TW:1];

  eye_word_check #(
    .W(W), .SETTLE_WORDS(SETTLE_WORDS), .CNT_W(CNT_W)
  ) u_check (
    .clk(clk), .rst(rst), .clear(start_acc), .en(sweeping),
    .rx_valid(rx_valid_i), .rx_word(rx_word_i), .pattern(pattern_i),
    .cmp_count(cmp_count_i), .tap_end(tap_end), .tap_pass(tap_pass)
  );

  eye_window_track #(.TW(TW)) u_track (
    .clk(clk), .rst(rst), .clear(start_acc), .rec(tap_end),
    .pass(tap_pass), .tap(tap_q), .any_pass(any_pass),
    .best_first(win_first), .best_last(win_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      load_q  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      load_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            state_q <= ST_SWEEP;
            tap_q   <= '0;
            load_q  <= 1'b1;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            first_q <= '0;
            last_q  <= '0;
          end
        end
        ST_SWEEP: begin
          if (tap_end) begin
            if (tap_q == TW'(TAPS - 1)) begin
              state_q <= ST_FINISH;
            end else begin
              tap_q  <= tap_q + 1'b1;
              load_q <= 1'b1;
            end
          end
        end
        ST_FINISH: begin
          state_q <= ST_IDLE;
          load_q  <= 1'b1;
          done_q  <= 1'b1;
          if (any_pass) begin
            tap_q   <= win_mid;
            first_q <= win_first;
            last_q  <= win_last;
            fail_q  <= 1'b0;
          end else begin
            tap_q  <= '0;
            fail_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tap_o   = tap_q;
  assign load_o  = load_q;
  assign done_o  = done_q;
  assign fail_o  = fail_q;
  assign first_o = first_q;
  assign last_o  = last_q;
endmodule

// File: rtl/eye_sweep_chk.sv
module eye_sweep_chk #(
  parameter int TW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [TW-1:0] tap_o,
  input logic          load_o,
  input logic          done_o,
  input logic          fail_o,
  input logic [TW-1:0] first_o,
  input logic [TW-1:0] last_o
);
  AST_TAP_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (tap_o != $past(tap_o)) |-> load_o); // R2

  AST_FAIL_PARKS_ZERO: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (done_o && tap_o == '0 && first_o == '0 && last_o == '0)); // R7

  AST_CENTER_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (done_o && !fail_o) |-> (first_o <= last_o && tap_o >= first_o && tap_o <= last_o)); // R6

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(tap_o) && $stable(fail_o))); // R9

  AST_DONE_CLEARS_ON_START: assert property (@(posedge clk) disable iff (rst)
    $fell(done_o) |-> $past(start_i)); // R9
endmodule

bind eye_sweep_ctrl eye_sweep_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .tap_o(tap_o), .load_o(load_o),
  .done_o(done_o), .fail_o(fail_o), .first_o(first_o), .last_o(last_o)
);

// File: tb/eye_sweep_ctrl_tb.sv
module eye_sweep_ctrl_tb;
  localparam int W      = 8;
  localparam int TAPS   = 32;
  localparam int SETTLE = 2;
  localparam int CNT_W  = 6;
  localparam int TW     = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic rx_valid_i = 1'b0;
  logic [W-1:0] rx_word_i = '0;
  logic [W-1:0] pattern_i = 8'h55;
  logic [CNT_W-1:0] cmp_count_i = 6'd5;
  logic [TW-1:0] tap_o, first_o, last_o;
  logic load_o, done_o, fail_o;

  always #4 clk = ~clk;

  eye_sweep_ctrl #(.W(W), .TAPS(TAPS), .SETTLE_WORDS(SETTLE), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .rx_valid_i(rx_valid_i),
    .rx_word_i(rx_word_i), .pattern_i(pattern_i), .cmp_count_i(cmp_count_i),
    .tap_o(tap_o), .load_o(load_o), .done_o(done_o), .fail_o(fail_o),
    .first_o(first_o), .last_o(last_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] pass_mask = '0;
  logic [31:0] late_mask = '0;
  bit gaps = 0;
  int wcnt = 0;
  int cyc  = 0;
  int lcount = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lane model
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (load_o) wcnt = 0;
      rx_valid_i = gaps ? ((cyc % 3) != 0) : 1'b1;
      if (!rx_valid_i || wcnt < SETTLE) rx_word_i = ~pattern_i;
      else if (!pass_mask[tap_o]) rx_word_i = pattern_i ^ 8'h10;
      else if (late_mask[tap_o] &&
               wcnt == SETTLE + ((cmp_count_i == 0) ? 1 : int'(cmp_count_i)) - 1)
        rx_word_i = pattern_i ^ 8'h01;
      else rx_word_i = pattern_i;
      if (rx_valid_i) wcnt++;
    end
  end

  // load monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && load_o) begin
        if (lcount < TAPS) chk("R2 tap step", int'(tap_o), lcount);
        lcount++;
      end
    end
  end

  task automatic run(input logic [31:0] pm, input logic [31:0] lm,
                     input int cmpv, input bit g, input bit mid_start, input string tag);
    logic [31:0] eff;
    int run_len, run_st, best_len, best_st, ef, el, et, t;
    bit ok;
    eff = pm & ~lm;
    run_len = 0; run_st = 0; best_len = 0; best_st = 0;
    for (int i = 0; i < TAPS; i++) begin
      if (eff[i]) begin
        if (run_len == 0) run_st = i;
        run_len++;
        if (run_len > best_len) begin best_len = run_len; best_st = run_st; end
      end else run_len = 0;
    end
    if (best_len == 0) begin ef = 0; el = 0; et = 0; end
    else begin ef = best_st; el = best_st + best_len - 1; et = (ef + el) / 2; end

    @(negedge clk);
    pass_mask = pm; late_mask = lm; gaps = g; cmp_count_i = CNT_W'(cmpv);
    lcount = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({"R9 done cleared ", tag}, int'(done_o), 0);
    t = 0; ok = 0;
    while (t < 5000) begin
      @(negedge clk);
      t++;
      if (mid_start && t == 100) start_i = 1'b1;
      if (mid_start && t == 101) start_i = 1'b0;
      if (done_o) begin ok = 1; break; end
    end
    if (!ok) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog %s actual=no done expected=done", tag);
    end
    @(negedge clk);
    chk({"R6 tap ", tag}, int'(tap_o), et);
    chk({"R5 first ", tag}, int'(first_o), ef);
    chk({"R5 last ", tag}, int'(last_o), el);
    chk({"R7 fail ", tag}, int'(fail_o), (best_len == 0) ? 1 : 0);
    chk({"R10 loads ", tag}, lcount, TAPS + 1);
    repeat (5) @(negedge clk);
    chk({"R9 done held ", tag}, int'(done_o), 1);
    chk({"R9 tap held ", tag}, int'(tap_o), et);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 tap", int'(tap_o), 0);
    chk("R1 load", int'(load_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 fail", int'(fail_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 first", int'(first_o), 0);
    chk("R1 last", int'(last_o), 0);

    run(32'h001F_FC00, 32'h0, 5, 0, 0, "R3 R4 clean window");
    run(32'h000B_F028, 32'h0, 5, 0, 0, "R5 scattered edges");
    run(32'h00F0_003C, 32'h0, 4, 0, 0, "R5 tie lower");
    run(32'h0000_0000, 32'h0, 5, 0, 0, "R7 no eye");
    run(32'hFFFF_FFFF, 32'h0, 3, 0, 0, "R6 open eye");
    run(32'h8000_0000, 32'h0, 1, 0, 0, "R6 single top");
    run(32'h01FF_FF00, 32'h0000_1000, 5, 0, 0, "R4 last word bad");
    run(32'h0007_FE00, 32'h0, 4, 1, 0, "R4 valid gaps");
    run(32'h0003_FF80, 32'h0, 5, 0, 1, "R8 start while busy");
    run(32'h0000_0F00, 32'h0, 0, 0, 0, "R4 zero count");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog global actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule